// File: doc/BRIEF.md
# Flash Block Blank-Check Engine

This engine confirms that one block of a flash array is fully erased. A host writes a two-step command: a setup byte, then a confirm byte, both tagged with the same block index. The engine then reads every word of that block in ascending order through a synchronous memory read port. A word counts as non-blank when any data bit reads as zero, or when the array raises its per-word over-erase flag for that word. The scan stops at the first non-blank word. If every word passes, the scan runs to the last word.

While a scan runs, the engine serves only status reads. Every other command is refused with a one-cycle reject pulse and leaves the scan untouched. The result appears in an 8-bit status register. The host also sees a mode output that tells whether reads return status or array data. A sequence that is started while another operation is held suspended is refused.

Top module: `blank_check_engine`

## Requirements
- R1: Byte 0xBC followed on the next command by 0xD0 with the same block index starts a scan. Status bit 7 (ready) reads 0 from the cycle after the confirm until the scan ends.
- R2: The scan issues one read per cycle at address {block index, word index}, word index counting up from 0 to BLK_WORDS-1. Read data and the over-erase flag arrive one cycle after the read request.
- R3: A word fails when any data bit is 0 or its over-erase flag is 1. A failed scan sets status bit 5.
- R4: The scan stops at the first failing word k. It issues min(k+2, BLK_WORDS) reads, and ready stays low for k+2 cycles. A blank block takes BLK_WORDS reads, and ready stays low for BLK_WORDS+1 cycles.
- R5: A valid or invalid command pair sets the mode output to 1 (status reads). When the engine is idle, byte 0xFF sets it to 0 and byte 0x70 sets it to 1.
- R6: Status layout: bit 7 is ready, bit 5 is failure, bit 4 is sequence error, and the other bits are 0. A passing scan leaves bit 5 unchanged. Bits 5 and 4 stay set until byte 0x50 is accepted while idle.
- R7: During a scan, any command other than 0x70 raises the reject output for one cycle, one cycle after the command. The refused command has no effect on status, mode or the scan. Byte 0x70 is accepted without a reject.
- R8: After 0xBC, a next command that is not 0xD0, or that carries a different block index, sets status bits 5 and 4. It starts no scan and issues no reads.
- R9: A setup byte while the suspended input is high is rejected with a reject pulse, and the engine stays idle. A confirm while the suspended input is high is a sequence error, as in R8.
- R10: After reset: status 0x80, mode 0, no read request, no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_data | input | 8 | Command byte |
| cmd_blk | input | BLK_W | Block index carried with the command |
| susp_in | input | 1 | Another operation is currently suspended |
| mem_rd_en | output | 1 | Array read request |
| mem_rd_addr | output | BLK_W+WORD_W | Array word address {block, word} |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after request |
| mem_rd_ovr | input | 1 | Over-erase flag for the returned word |
| status | output | 8 | Status register |
| stat_mode | output | 1 | 1: reads return status, 0: array data |
| cmd_rej | output | 1 | One-cycle pulse for a refused command |

## Verification
The scan is exercised on a fully erased block, on a block with one zero bit in a middle word, on a block whose last word carries only the over-erase flag, and on a block whose first word is programmed. Together these cases separate the pass path from the fail path, data-bit detection from flag detection, and early stop from the read-count cap at the block end. A burst of mixed commands during a scan, with a failure bit already set, shows that refused commands cannot clear status, change mode or disturb the scan. Bad confirm bytes, mismatched block indexes and a raised suspended input each yield the sequence error and no reads.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'hBC;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLR     = 8'h50;
  localparam logic [7:0] CMD_RDSR    = 8'h70;
  localparam logic [7:0] CMD_RDARR   = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SCAN  = 2'd2
  } bc_state_t;

  typedef struct packed {
    logic setup;
    logic confirm;
    logic clr;
    logic rdsr;
    logic rdarr;
  } cmd_kind_t;
endpackage

// File: rtl/bc_cmd_decode.sv
module bc_cmd_decode
  import bc_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] data,
  output cmd_kind_t  kind
);
  always_comb begin
    kind         = '0;
    kind.setup   = valid && (data == CMD_SETUP);
    kind.confirm = valid && (data == CMD_CONFIRM);
    kind.clr     = valid && (data == CMD_CLR);
    kind.rdsr    = valid && (data == CMD_RDSR);
    kind.rdarr   = valid && (data == CMD_RDARR);
  end
endmodule

// File: rtl/bc_addr_gen.sv
module bc_addr_gen #(
  parameter int WORDS  = 16,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              halt,
  output logic              rd_en,
  output logic [WORD_W-1:0] idx,
  output logic              idx_last
);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(WORDS - 1);

  assign idx_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en <= 1'b0;
      idx   <= '0;
    end else if (halt) begin
      rd_en <= 1'b0;
    end else if (start) begin
      rd_en <= 1'b1;
      idx   <= '0;
    end else if (rd_en) begin
      if (idx_last) rd_en <= 1'b0;
      else          idx   <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bc_word_check.sv
module bc_word_check #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              issue_en,
  input  logic              issue_last,
  input  logic [DATA_W-1:0] data,
  input  logic              ovr,
  output logic              word_bad,
  output logic              pass_end
);
  logic chk_v;
  logic chk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v    <= 1'b0;
      chk_last <= 1'b0;
    end else begin
      chk_v    <= issue_en && !flush;
      chk_last <= issue_en && issue_last && !flush;
    end
  end

  assign word_bad = chk_v && (!(&data) || ovr);
  assign pass_end = chk_last && !word_bad;
endmodule

// File: rtl/blank_check_engine.sv
module blank_check_engine
  import bc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  localparam int BLK_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int WORD_W   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_data,
  input  logic [BLK_W-1:0]        cmd_blk,
  input  logic                    susp_in,
  output logic                    mem_rd_en,
  output logic [BLK_W+WORD_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]       mem_rd_data,
  input  logic                    mem_rd_ovr,
  output logic [7:0]              status,
  output logic                    stat_mode,
  output logic                    cmd_rej
);
  cmd_kind_t         kind;
  bc_state_t         st_q, st_n;
  logic [BLK_W-1:0]  blk_q, blk_n;
  logic              fail_q, fail_n;
  logic              seq_q, seq_n;
  logic              mode_n;
  logic              rej_n;
  logic              start;
  logic              word_bad;
  logic              pass_end;
  logic [WORD_W-1:0] word_idx;
  logic              word_last;

  bc_cmd_decode u_dec (
    .valid (cmd_valid),
    .data  (cmd_data),
    .kind  (kind)
  );

  bc_addr_gen #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .halt     (word_bad),
    .rd_en    (mem_rd_en),
    .idx      (word_idx),
    .idx_last (word_last)
  );

  bc_word_check #(.DATA_W(DATA_W)) u_chk_word (
    .clk        (clk),
    .rst        (rst),
    .flush      (word_bad),
    .issue_en   (mem_rd_en),
    .issue_last (word_last),
    .data       (mem_rd_data),
    .ovr        (mem_rd_ovr),
    .word_bad   (word_bad),
    .pass_end   (pass_end)
  );

  assign mem_rd_addr = {blk_q, word_idx};

  always_comb begin
    st_n   = st_q;
    blk_n  = blk_q;
    fail_n = fail_q;
    seq_n  = seq_q;
    mode_n = stat_mode;
    rej_n  = 1'b0;
    start  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (kind.setup) begin
          if (susp_in) begin
            rej_n = 1'b1;
          end else begin
            st_n  = ST_ARMED;
            blk_n = cmd_blk;
          end
        end else if (kind.clr) begin
          fail_n = 1'b0;
          seq_n  = 1'b0;
        end else if (kind.rdsr) begin
          mode_n = 1'b1;
        end else if (kind.rdarr) begin
          mode_n = 1'b0;
        end
      end
      ST_ARMED: begin
        if (cmd_valid) begin
          mode_n = 1'b1;
          if (kind.confirm && (cmd_blk == blk_q) && !susp_in) begin
            st_n  = ST_SCAN;
            start = 1'b1;
          end else begin
            fail_n = 1'b1;
            seq_n  = 1'b1;
            st_n   = ST_IDLE;
          end
        end
      end
      ST_SCAN: begin
        if (cmd_valid && !kind.rdsr) rej_n = 1'b1;
        if (word_bad) begin
          fail_n = 1'b1;
          st_n   = ST_IDLE;
        end else if (pass_end) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      blk_q     <= '0;
      fail_q    <= 1'b0;
      seq_q     <= 1'b0;
      stat_mode <= 1'b0;
      cmd_rej   <= 1'b0;
      status    <= 8'h80;
    end else begin
      st_q      <= st_n;
      blk_q     <= blk_n;
      fail_q    <= fail_n;
      seq_q     <= seq_n;
      stat_mode <= mode_n;
      cmd_rej   <= rej_n;
      status    <= {st_n != ST_SCAN, 1'b0, fail_n, seq_n, 4'b0000};
    end
  end
endmodule

// File: rtl/blank_check_engine_chk.sv
module blank_check_engine_chk
  import bc_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  localparam int BLK_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int WORD_W   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int AW       = BLK_W + WORD_W
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [7:0]    cmd_data,
  input logic          cmd_rej,
  input logic [7:0]    status,
  input logic          stat_mode,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr
);
  // R1: no array read while ready is high
  a_r1_busy_when_reading: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !status[7]);

  // R2: one block per scan
  a_r2_same_block: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_rd_addr[AW-1:WORD_W] == $past(mem_rd_addr[AW-1:WORD_W])));

  // R2: ascending word order
  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_rd_addr[WORD_W-1:0] == WORD_W'($past(mem_rd_addr[WORD_W-1:0]) + 1'b1)));

  // R5: status mode holds for the whole scan
  a_r5_status_mode_in_scan: assert property (@(posedge clk) disable iff (rst)
    !status[7] |-> stat_mode);

  // R7: a reject follows a command that is not a status read
  a_r7_reject_cause: assert property (@(posedge clk) disable iff (rst)
    cmd_rej |-> ($past(cmd_valid) && ($past(cmd_data) != CMD_RDSR)));

  // R6: failure bit stays until a clear command
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(status[5]) && !($past(cmd_valid) && ($past(cmd_data) == CMD_CLR)))
      |-> status[5]);
endmodule

bind blank_check_engine blank_check_engine_chk #(
  .NUM_BLK   (NUM_BLK),
  .BLK_WORDS (BLK_WORDS)
) u_bc_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_data    (cmd_data),
  .cmd_rej     (cmd_rej),
  .status      (status),
  .stat_mode   (stat_mode),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr)
);

// File: tb/blank_check_engine_test.sv
`timescale 1ns/1ps
module blank_check_engine_test;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int NW = 16;
  localparam int BW = 2;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_data = 8'h00;
  logic [BW-1:0] cmd_blk = '0;
  logic          susp_in = 1'b0;
  logic          mem_rd_en;
  logic [BW+WW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '1;
  logic          mem_rd_ovr = 1'b0;
  logic [7:0]    status;
  logic          stat_mode;
  logic          cmd_rej;

  logic [DW-1:0] mem [NB*NW];
  logic          ovr [NB*NW];

  always #2.5 clk = ~clk;

  blank_check_engine #(.DATA_W(DW), .NUM_BLK(NB), .BLK_WORDS(NW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_blk(cmd_blk), .susp_in(susp_in), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_ovr(mem_rd_ovr), .status(status), .stat_mode(stat_mode),
    .cmd_rej(cmd_rej)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr];
      mem_rd_ovr  <= ovr[mem_rd_addr];
    end
  end

  // behavioural reference model
  int   m_state = 0;
  int   m_blk = 0, m_cnt = 0, m_word = 0, m_reads = 0, m_rejcnt = 0;
  bit   m_wf = 0, m_fail = 0, m_seq = 0, m_mode = 0, m_rej = 0;
  bit   m_rdchk = 0, m_rdgood = 1;
  logic [7:0] m_status;
  assign m_status = {(m_state != 2), 1'b0, m_fail, m_seq, 4'b0000};

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_fail = 0; m_seq = 0; m_mode = 0; m_rej = 0; m_rdchk = 0;
    end else begin
      bit rj;
      rj = 0;
      m_rdchk = mem_rd_en;
      if (mem_rd_en) begin
        m_rdgood = (int'(mem_rd_addr) == m_blk * NW + m_word);
        m_word++;
        m_reads++;
      end
      if (cmd_rej) m_rejcnt++;
      case (m_state)
        0: if (cmd_valid) begin
             if (cmd_data == 8'hBC) begin
               if (susp_in) rj = 1;
               else begin m_state = 1; m_blk = int'(cmd_blk); end
             end else if (cmd_data == 8'h50) begin m_fail = 0; m_seq = 0; end
             else if (cmd_data == 8'h70) m_mode = 1;
             else if (cmd_data == 8'hFF) m_mode = 0;
           end
        1: if (cmd_valid) begin
             m_mode = 1;
             if (cmd_data == 8'hD0 && int'(cmd_blk) == m_blk && !susp_in) begin
               int k;
               k = NW;
               for (int i = 0; i < NW; i++)
                 if (k == NW && (mem[m_blk*NW+i] != '1 || ovr[m_blk*NW+i])) k = i;
               m_wf = (k < NW);
               m_cnt = m_wf ? k + 2 : NW + 1;
               m_word = 0; m_reads = 0;
               m_state = 2;
             end else begin
               m_fail = 1; m_seq = 1; m_state = 0;
             end
           end
        default: begin
             if (cmd_valid && cmd_data != 8'h70) rj = 1;
             m_cnt--;
             if (m_cnt == 0) begin
               m_state = 0;
               if (m_wf) m_fail = 1;
             end
           end
      endcase
      m_rej = rj;
    end
  end

  // per-clock comparison against the model
  int ta = 0, ba = 0;
  always @(negedge clk) begin
    if (!rst) begin
      ta++;
      if (status !== m_status) begin
        ba++; $display("FAIL R6 status actual=%h expected=%h", status, m_status);
      end
      ta++;
      if (stat_mode !== m_mode) begin
        ba++; $display("FAIL R5 mode actual=%b expected=%b", stat_mode, m_mode);
      end
      ta++;
      if (cmd_rej !== m_rej) begin
        ba++; $display("FAIL R7 reject actual=%b expected=%b", cmd_rej, m_rej);
      end
      if (m_rdchk) begin
        ta++;
        if (!m_rdgood) begin
          ba++; $display("FAIL R2 read address actual=%0d expected=word %0d of block %0d",
                         mem_rd_addr, m_word - 1, m_blk);
        end
      end
    end
  end

  // directed scenarios
  int tb_n = 0, bb = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tb_n++;
    if (!ok) begin
      bb++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input int b);
    cmd_valid = 1'b1; cmd_data = d; cmd_blk = BW'(b);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int busy);
    busy = 0;
    while (!status[7] && busy < 200) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic fill_blank();
    for (int i = 0; i < NB*NW; i++) begin mem[i] = '1; ovr[i] = 1'b0; end
  endtask

  initial begin
    int busy, r0;
    fill_blank();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 8'h80, "R10 reset status", status, 8'h80);
    chk(stat_mode == 1'b0, "R10 reset mode", stat_mode, 0);
    chk(mem_rd_en == 1'b0 && cmd_rej == 1'b0, "R10 reset outputs", mem_rd_en, 0);

    // blank block 1
    send(8'hBC, 1); send(8'hD0, 1);
    chk(status[7] == 1'b0, "R1 ready low in scan", status[7], 0);
    wait_done(busy);
    chk(busy == NW + 1, "R4 blank busy cycles", busy, NW + 1);
    chk(m_reads == NW, "R2 blank read count", m_reads, NW);
    chk(status == 8'h80, "R6 pass status", status, 8'h80);
    chk(stat_mode == 1'b1, "R5 status mode after check", stat_mode, 1);

    // zero bit in word 5 of block 2
    mem[2*NW+5] = 16'hFFFE;
    send(8'hBC, 2); send(8'hD0, 2);
    wait_done(busy);
    chk(busy == 7, "R4 early stop busy", busy, 7);
    chk(m_reads == 7, "R4 early stop reads", m_reads, 7);
    chk(status == 8'hA0, "R3 fail status", status, 8'hA0);

    // commands during scan with failure bit already set
    r0 = m_rejcnt;
    send(8'hBC, 1); send(8'hD0, 1);
    send(8'hFF, 1); send(8'h50, 1); send(8'hB0, 1); send(8'hBC, 1); send(8'h70, 1);
    wait_done(busy);
    @(negedge clk);
    chk(m_rejcnt - r0 == 4, "R7 reject count", m_rejcnt - r0, 4);
    chk(status == 8'hA0, "R7 clear ignored in scan", status, 8'hA0);
    chk(stat_mode == 1'b1, "R7 array read ignored in scan", stat_mode, 1);

    send(8'h50, 0);
    chk(status == 8'h80, "R6 clear status", status, 8'h80);

    // over-erase flag only, last word of block 3
    ovr[3*NW+NW-1] = 1'b1;
    send(8'hBC, 3); send(8'hD0, 3);
    wait_done(busy);
    chk(busy == NW + 1, "R4 last word busy", busy, NW + 1);
    chk(m_reads == NW, "R4 read cap", m_reads, NW);
    chk(status == 8'hA0, "R3 over-erase fail", status, 8'hA0);
    send(8'h50, 0);

    // first word programmed in block 0
    mem[0] = 16'h7FFF;
    send(8'hBC, 0); send(8'hD0, 0);
    wait_done(busy);
    chk(busy == 2 && m_reads == 2, "R4 first word stop", m_reads, 2);
    send(8'h50, 0);

    // bad confirm byte, then mismatched block
    send(8'hFF, 0);
    r0 = m_reads;
    send(8'hBC, 1); send(8'h70, 1);
    @(negedge clk);
    chk(status == 8'hB0, "R8 bad confirm byte", status, 8'hB0);
    chk(stat_mode == 1'b1, "R5 mode after bad pair", stat_mode, 1);
    send(8'h50, 0);
    send(8'hBC, 1); send(8'hD0, 2);
    @(negedge clk);
    chk(status == 8'hB0, "R8 block mismatch", status, 8'hB0);
    chk(m_reads == r0, "R8 no reads", m_reads, r0);
    send(8'h50, 0);

    // suspended input
    r0 = m_rejcnt;
    susp_in = 1'b1;
    send(8'hBC, 1);
    susp_in = 1'b0;
    send(8'hD0, 1);
    @(negedge clk);
    chk(m_rejcnt - r0 == 1, "R9 setup rejected", m_rejcnt - r0, 1);
    chk(status == 8'h80, "R9 stays idle", status, 8'h80);
    send(8'hBC, 1);
    susp_in = 1'b1;
    send(8'hD0, 1);
    susp_in = 1'b0;
    chk(status == 8'hB0, "R9 confirm while suspended", status, 8'hB0);
    send(8'h50, 0);

    // mode switching while idle
    send(8'hFF, 0);
    chk(stat_mode == 1'b0, "R5 array mode", stat_mode, 0);
    send(8'h70, 0);
    chk(stat_mode == 1'b1, "R5 status read mode", stat_mode, 1);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", ta + tb_n, ba + bb);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", ta + tb_n + 1, ba + bb + 1);
    $finish;
  end
endmodule